// File: doc/BRIEF.md
# Parameter Safeload Transfer Controller

This block lets software change a group of processing coefficients without tearing a sample frame. It has five staging slots. Each slot holds a target address and a data word, and software loads them through a simple register-write port. Software then sets a start bit. The controller waits for the next frame boundary and copies the staged slots into the parameter RAM in one burst. It copies only the slots whose data has been written since the previous transfer.

A down-counter marks the frame boundaries. A two-bit rate code sets its length to the full base length, to half of it, or to a quarter of it. While a transfer is pending or running, the write port drops its ready signal. The start bit reads back as busy and clears itself once the last RAM write has gone out.

Top module: `param_safeload`

## Requirements
- R1: The register port holds five slots. Register addresses 0..4 are the target-address registers of slots 0..4. Addresses 8..12 are the data registers of slots 0..4. Address 15 is the control register: bit 0 is start, bits [2:1] are the rate code. A write takes effect only in a cycle where `reg_wr` and `reg_ready` are both high.
- R2: Writing a slot's data register marks that slot dirty. Writing only its address register does not mark it dirty.
- R3: Writing 1 to control bit 0 sets `start_busy`. Writing 0 to that bit has no effect. `start_busy` returns to 0 by itself one cycle after the last RAM write of the transfer.
- R4: A started transfer waits for the next frame boundary. Its first RAM write appears two cycles after the cycle in which `frame_edge` is high.
- R5: Only dirty slots are written to the RAM, in ascending slot order, one write per cycle with no gaps. Each write carries the slot's address register on `ram_addr` and its data register on `ram_wdata`.
- R6: A slot's dirty mark clears once the slot has been copied. A later start with no new data writes produces no RAM write.
- R7: A start with no dirty slot completes at the next frame boundary with no RAM write, and `start_busy` still clears.
- R8: The rate code sets the frame length: code 00 gives BASE_LEN cycles, 01 gives BASE_LEN/2, and 10 gives BASE_LEN/4. A new code takes effect from the next frame reload.
- R9: Writing the reserved rate code 11 leaves the current rate code and frame length unchanged.
- R10: `reg_ready` is low while a transfer is pending or running. A write offered then changes no slot and no dirty mark.
- R11: Synchronous active-high reset clears all dirty marks and `start_busy`, sets the rate code to 00 and holds `ram_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | DW | Register write data |
| reg_ready | output | 1 | High when a register write is accepted |
| start_busy | output | 1 | Readback of the start bit (transfer pending or running) |
| rate_code | output | 2 | Readback of the active rate code |
| frame_edge | output | 1 | One-cycle frame boundary pulse |
| ram_we | output | 1 | Parameter RAM write enable |
| ram_addr | output | PAW | Parameter RAM write address |
| ram_wdata | output | DW | Parameter RAM write data |

## Verification
The bench builds the block with BASE_LEN set to 16, DW set to 16 and PAW set to 10. With these values the three frame lengths are 16, 8 and 4 cycles. Every rate code, including the reserved one, can then be measured within a few dozen cycles, and many transfers fit inside the run. The narrow data path also keeps the expected address and data pairs easy to read when a comparison fails.

// File: rtl/safeload_pkg.sv
package safeload_pkg;

    localparam int SLOT_CNT   = 5;
    localparam int SLOT_IDX_W = 3;
    localparam int REG_IDX_W  = 4;

    localparam logic [REG_IDX_W-1:0] CTRL_REG  = 4'd15;
    localparam logic [REG_IDX_W-1:0] DATA_BASE = 4'd8;

    typedef enum logic [1:0] {
        RATE_X1   = 2'b00,
        RATE_X2   = 2'b01,
        RATE_X4   = 2'b10,
        RATE_RSVD = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_COPY,
        SEQ_DONE
    } seq_e;

    typedef struct packed {
        logic                  ctl_sel;
        logic                  addr_sel;
        logic                  data_sel;
        logic [SLOT_IDX_W-1:0] slot;
    } reg_decode_t;

    function automatic reg_decode_t decode_reg(input logic [REG_IDX_W-1:0] a);
        reg_decode_t d;
        d.ctl_sel  = (a == CTRL_REG);
        d.addr_sel = (a < REG_IDX_W'(SLOT_CNT));
        d.data_sel = (a >= DATA_BASE) && (a < DATA_BASE + REG_IDX_W'(SLOT_CNT));
        d.slot     = a[SLOT_IDX_W-1:0];
        return d;
    endfunction

    function automatic logic [SLOT_CNT-1:0] lowest_set(input logic [SLOT_CNT-1:0] m);
        logic [SLOT_CNT-1:0] neg;
        neg = ~m + 1'b1;
        return m & neg;
    endfunction

    function automatic logic [SLOT_IDX_W-1:0] onehot_idx(input logic [SLOT_CNT-1:0] m);
        logic [SLOT_IDX_W-1:0] idx;
        idx = '0;
        for (int k = 0; k < SLOT_CNT; k++) begin
            if (m[k]) idx = SLOT_IDX_W'(k);
        end
        return idx;
    endfunction

endpackage

// File: rtl/sl_stage_bank.sv
module sl_stage_bank
    import safeload_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  reg_decode_t         dec,
    input  logic [DW-1:0]       wdata,
    input  logic [SLOT_CNT-1:0] clr_mask,
    output logic [SLOT_CNT-1:0] dirty,
    output logic [AW-1:0]       slot_addr [SLOT_CNT],
    output logic [DW-1:0]       slot_data [SLOT_CNT]
);

    for (genvar i = 0; i < SLOT_CNT; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (dec.slot == SLOT_IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_addr[i] <= '0;
            end else if (hit && dec.addr_sel) begin
                slot_addr[i] <= wdata[AW-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_data[i] <= '0;
                dirty[i]     <= 1'b0;
            end else if (hit && dec.data_sel) begin
                slot_data[i] <= wdata;
                dirty[i]     <= 1'b1;
            end else if (clr_mask[i]) begin
                dirty[i]     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sl_frame_timer.sv
module sl_frame_timer
    import safeload_pkg::*;
#(
    parameter int BASE_LEN = 1024
) (
    input  logic  clk,
    input  logic  rst,
    input  rate_e rate,
    output logic  tick
);

    localparam int CW = $clog2(BASE_LEN);
    localparam logic [CW-1:0] LEN_X1 = CW'(BASE_LEN - 1);
    localparam logic [CW-1:0] LEN_X2 = CW'(BASE_LEN / 2 - 1);
    localparam logic [CW-1:0] LEN_X4 = CW'(BASE_LEN / 4 - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;

    always_comb begin
        case (rate)
            RATE_X2: reload = LEN_X2;
            RATE_X4: reload = LEN_X4;
            default: reload = LEN_X1;
        endcase
    end

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= LEN_X1;
        end else if (tick) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/sl_sequencer.sv
module sl_sequencer
    import safeload_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_req,
    input  logic                  tick,
    input  logic [SLOT_CNT-1:0]   dirty,
    output logic                  busy,
    output logic                  sel_valid,
    output logic [SLOT_IDX_W-1:0] sel_slot,
    output logic [SLOT_CNT-1:0]   clr_mask
);

    seq_e                state;
    logic [SLOT_CNT-1:0] pending;
    logic [SLOT_CNT-1:0] pick;
    logic [SLOT_CNT-1:0] remain;

    assign pick      = lowest_set(pending);
    assign remain    = pending & ~pick;
    assign sel_valid = (state == SEQ_COPY);
    assign sel_slot  = onehot_idx(pick);
    assign clr_mask  = sel_valid ? pick : '0;
    assign busy      = (state != SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            pending <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (start_req) state <= SEQ_WAIT;
                SEQ_WAIT: if (tick) begin
                    pending <= dirty;
                    state   <= (|dirty) ? SEQ_COPY : SEQ_DONE;
                end
                SEQ_COPY: begin
                    pending <= remain;
                    if (remain == '0) state <= SEQ_DONE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/param_safeload.sv
module param_safeload
    import safeload_pkg::*;
#(
    parameter int BASE_LEN = 1024,
    parameter int DW       = 32,
    parameter int PAW      = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [3:0]     reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic           reg_ready,
    output logic           start_busy,
    output logic [1:0]     rate_code,
    output logic           frame_edge,
    output logic           ram_we,
    output logic [PAW-1:0] ram_addr,
    output logic [DW-1:0]  ram_wdata
);

    reg_decode_t           dec;
    logic                  wr_ok;
    logic                  start_req;
    logic                  busy;
    logic                  sel_valid;
    logic [SLOT_IDX_W-1:0] sel_slot;
    logic [SLOT_CNT-1:0]   clr_mask;
    logic [SLOT_CNT-1:0]   dirty;
    logic [PAW-1:0]        slot_addr [SLOT_CNT];
    logic [DW-1:0]         slot_data [SLOT_CNT];
    rate_e                 rate_q;

    assign dec       = decode_reg(reg_addr);
    assign reg_ready = !busy;
    assign wr_ok     = reg_wr && reg_ready;
    assign start_req = wr_ok && dec.ctl_sel && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= RATE_X1;
        end else if (wr_ok && dec.ctl_sel && (reg_wdata[2:1] != RATE_RSVD)) begin
            rate_q <= rate_e'(reg_wdata[2:1]);
        end
    end

    sl_stage_bank #(.AW(PAW), .DW(DW)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_ok),
        .dec      (dec),
        .wdata    (reg_wdata),
        .clr_mask (clr_mask),
        .dirty    (dirty),
        .slot_addr(slot_addr),
        .slot_data(slot_data)
    );

    sl_frame_timer #(.BASE_LEN(BASE_LEN)) u_timer (
        .clk (clk),
        .rst (rst),
        .rate(rate_q),
        .tick(frame_edge)
    );

    sl_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_req(start_req),
        .tick     (frame_edge),
        .dirty    (dirty),
        .busy     (busy),
        .sel_valid(sel_valid),
        .sel_slot (sel_slot),
        .clr_mask (clr_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we    <= sel_valid;
            ram_addr  <= slot_addr[sel_slot];
            ram_wdata <= slot_data[sel_slot];
        end
    end

    assign start_busy = busy;
    assign rate_code  = rate_q;

endmodule

// File: rtl/sl_safeload_chk.sv
module sl_safeload_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_busy,
    input logic       frame_edge,
    input logic       ram_we,
    input logic [1:0] rate_code
);

    // R5: RAM writes only occur inside a transfer
    p_write_in_xfer_r5: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> start_busy);

    // R4: a burst starts two cycles after a frame boundary
    p_burst_after_edge_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we) |-> $past(frame_edge, 2));

    // R3: the start bit drops only once the writes are over
    p_clear_after_writes_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(start_busy) |-> !ram_we);

    // R9: the reserved code never becomes active
    p_rate_legal_r9: assert property (@(posedge clk) disable iff (rst)
        rate_code != 2'b11);

    // R11: state right after reset
    p_reset_state_r11: assert property (@(posedge clk)
        $past(rst) |-> (!start_busy && !ram_we && rate_code == 2'b00));

endmodule

bind param_safeload sl_safeload_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_busy(start_busy),
    .frame_edge(frame_edge),
    .ram_we    (ram_we),
    .rate_code (rate_code)
);

// File: tb/test_param_safeload.sv
module test_param_safeload;

    localparam int CLK_PERIOD = 10;
    localparam int BASE_LEN   = 16;
    localparam int DW         = 16;
    localparam int PAW        = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           reg_wr = 1'b0;
    logic [3:0]     reg_addr = '0;
    logic [DW-1:0]  reg_wdata = '0;
    logic           reg_ready, start_busy, frame_edge, ram_we;
    logic [1:0]     rate_code;
    logic [PAW-1:0] ram_addr;
    logic [DW-1:0]  ram_wdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    param_safeload #(.BASE_LEN(BASE_LEN), .DW(DW), .PAW(PAW)) i_param_safeload (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(reg_ready), .start_busy(start_busy),
        .rate_code(rate_code), .frame_edge(frame_edge), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [PAW+DW-1:0] exp_q[$];
    int wr_seen = 0;
    int cur_burst = 0;
    int last_burst = 0;
    logic fe_d1 = 1'b0, fe_d2 = 1'b0, we_d1 = 1'b0;

    logic [PAW-1:0] m_addr [5];
    logic [DW-1:0]  m_data [5];
    logic           m_dirty [5];
    logic [1:0]     m_rate = 2'b00;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (ram_we) begin
                wr_seen++;
                cur_burst++;
                if (!we_d1) check(fe_d2, "R4 burst start after frame_edge", fe_d2, 1);
                if (exp_q.size() == 0) begin
                    check(0, "R5 unexpected RAM write", ram_addr, -1);
                end else begin
                    logic [PAW+DW-1:0] e;
                    e = exp_q.pop_front();
                    check({ram_addr, ram_wdata} == e, "R5 RAM write addr/data",
                          {ram_addr, ram_wdata}, e);
                end
            end else if (cur_burst != 0) begin
                last_burst = cur_burst;
                cur_burst = 0;
            end
            fe_d2 = fe_d1;
            fe_d1 = frame_edge;
            we_d1 = ram_we;
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic stage_addr(input int s, input logic [PAW-1:0] a);
        wr_reg(4'(s), DW'(a));
        m_addr[s] = a;
    endtask

    task automatic stage_data(input int s, input logic [DW-1:0] d);
        wr_reg(4'(8 + s), d);
        m_data[s] = d;
        m_dirty[s] = 1'b1;
    endtask

    task automatic start_xfer();
        for (int s = 0; s < 5; s++) begin
            if (m_dirty[s]) begin
                exp_q.push_back({m_addr[s], m_data[s]});
                m_dirty[s] = 1'b0;
            end
        end
        wr_reg(4'd15, DW'({m_rate, 1'b1}));
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (start_busy && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(!start_busy, req, start_busy, 0);
        @(negedge clk);
    endtask

    task automatic measure(output int len);
        len = 0;
        do @(negedge clk); while (!frame_edge);
        do begin @(negedge clk); len++; end while (!frame_edge);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int len, w0;
        for (int s = 0; s < 5; s++) begin m_addr[s] = '0; m_data[s] = '0; m_dirty[s] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check(!start_busy && reg_ready, "R11 busy clear after reset", start_busy, 0);
        check(rate_code == 2'b00, "R11 rate code reset", rate_code, 0);
        check(!ram_we, "R11 ram_we low", ram_we, 0);

        // R8 default length
        measure(len);
        check(len == BASE_LEN, "R8 frame length code 00", len, BASE_LEN);

        // R1 R5 out-of-order staging, ascending copy
        stage_addr(4, 10'h3A1); stage_data(4, 16'hC0DE);
        stage_addr(0, 10'h005); stage_data(0, 16'h1111);
        stage_addr(2, 10'h200); stage_data(2, 16'h2222);
        w0 = wr_seen;
        start_xfer();
        check(start_busy, "R3 start bit reads busy", start_busy, 1);
        wait_idle("R3 start bit self-clears");
        check(wr_seen - w0 == 3, "R5 three dirty slots copied", wr_seen - w0, 3);
        check(last_burst == 3, "R5 back-to-back writes", last_burst, 3);
        check(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);

        // R6 R7 no dirty slot
        w0 = wr_seen;
        start_xfer();
        wait_idle("R7 empty start clears");
        check(wr_seen == w0, "R6 copied slots no longer dirty", wr_seen - w0, 0);

        // R2 address-only write does not dirty
        stage_addr(1, 10'h155);
        w0 = wr_seen;
        start_xfer();
        wait_idle("R2 address-only start clears");
        check(wr_seen == w0, "R2 address write not dirty", wr_seen - w0, 0);
        stage_data(1, 16'hABCD);
        w0 = wr_seen;
        start_xfer();
        wait_idle("R2 data write transfer clears");
        check(wr_seen - w0 == 1, "R2 data write makes dirty", wr_seen - w0, 1);

        // R10 writes ignored while busy
        stage_addr(3, 10'h033); stage_data(3, 16'h3333);
        start_xfer();
        check(!reg_ready, "R10 ready low while busy", reg_ready, 0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 16'hDEAD;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_idle("R10 transfer clears");
        w0 = wr_seen;
        start_xfer();
        wait_idle("R10 second start clears");
        check(wr_seen == w0, "R10 blocked write left slot 0 clean", wr_seen - w0, 0);

        // R8 rate 01 and 10
        m_rate = 2'b01;
        wr_reg(4'd15, DW'({m_rate, 1'b0}));
        check(rate_code == 2'b01, "R8 rate code 01 readback", rate_code, 1);
        check(!start_busy, "R3 writing 0 to start ignored", start_busy, 0);
        measure(len); measure(len);
        check(len == BASE_LEN / 2, "R8 frame length code 01", len, BASE_LEN / 2);
        m_rate = 2'b10;
        wr_reg(4'd15, DW'({m_rate, 1'b0}));
        measure(len); measure(len);
        check(len == BASE_LEN / 4, "R8 frame length code 10", len, BASE_LEN / 4);

        // R9 reserved code ignored
        wr_reg(4'd15, DW'(3'b110));
        check(rate_code == 2'b10, "R9 reserved code keeps rate", rate_code, 2);
        measure(len); measure(len);
        check(len == BASE_LEN / 4, "R9 length unchanged", len, BASE_LEN / 4);

        // R1 R5 all five slots at quarter rate
        for (int s = 0; s < 5; s++) begin
            stage_addr(s, PAW'(16 * s + 7));
            stage_data(s, DW'(16'h5000 + s));
        end
        w0 = wr_seen;
        start_xfer();
        wait_idle("R3 full transfer clears");
        check(wr_seen - w0 == 5, "R1 five slots copied", wr_seen - w0, 5);
        check(last_burst == 5, "R5 five writes back-to-back", last_burst, 5);

        // R8 back to code 00
        m_rate = 2'b00;
        wr_reg(4'd15, DW'({m_rate, 1'b0}));
        measure(len); measure(len);
        check(len == BASE_LEN, "R8 frame length back to 00", len, BASE_LEN);

        // R11 reset mid-transfer
        stage_data(2, 16'h7777);
        wr_reg(4'd15, 16'h0001);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(!start_busy, "R11 reset clears start bit", start_busy, 0);
        m_dirty[2] = 1'b0;
        w0 = wr_seen;
        start_xfer();
        wait_idle("R11 start after reset clears");
        check(wr_seen == w0, "R11 reset cleared dirty marks", wr_seen - w0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule